// File: doc/BRIEF.md
# Misaligned Load Splitter

This block sits between a core that issues 1-, 2- or 4-byte loads at any byte address and a memory bus that only moves whole, aligned data words. For each accepted load it works out which word or words hold the requested bytes. It issues one aligned bus read when the bytes fit in a single word, and two reads to consecutive word addresses when they cross a word boundary. It then selects and joins the bytes into a right-aligned, zero-extended little-endian result.

A mode input turns on strict alignment. In that mode a load whose address is not a multiple of its size gets no bus traffic at all; it is answered with a fault response. One load is in flight at a time. Requests use a valid/ready handshake, and the answer is a single-cycle response pulse.

Top module: `ld_split_unit`

## Requirements
- R1: While reset is held, and directly after it, `req_ready` is 1 and `rsp_valid` and `bus_req_valid` are 0.
- R2: Every bus read carries a word address, which is the byte address with its lowest log2(DATA_W/8) bits removed. The bus always returns a full word.
- R3: A byte load (size code 0) issues one bus read. The addressed byte appears in `rsp_data[7:0]` and bits 31:8 are zero, for every byte offset.
- R4: A load is aligned when its address modulo its size is zero. Every aligned load issues exactly one bus read.
- R5: In split mode (`trap_mode` = 0), a misaligned load whose bytes all lie in one word (for example 2 bytes at offset 1) issues exactly one bus read and returns the correct bytes.
- R6: A load whose bytes cross a word boundary (2 bytes at offset 3, or 4 bytes at offset 1, 2 or 3) issues exactly two reads: first at word address W, then at W+1, which wraps at the top of the address space.
- R7: The result is little-endian: the byte at the lowest address lands in bits 7:0 and higher addresses go to higher bytes. Bits above the load size are zero. Size codes: 0 = 1 byte, 1 = 2 bytes, 2 and 3 = 4 bytes.
- R8: When `trap_mode` is 1 as a misaligned load is accepted, no bus read is issued. The load is answered by a single `rsp_valid` cycle with `rsp_fault` = 1 and `rsp_data` = 0.
- R9: When `trap_mode` is 1, aligned loads complete normally with `rsp_fault` = 0.
- R10: Only one request is outstanding. `req_ready` is low from the cycle after acceptance until the response. `rsp_valid` is high for exactly one cycle per accepted request, and `req_ready` is high again in the cycle after it.
- R11: `trap_mode` is sampled only in the cycle a request is accepted. Changing it while a load is in progress has no effect on that load.
- R12: While `bus_req_valid` is high and `bus_req_ready` is low, the request stays valid and `bus_word_addr` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trap_mode | input | 1 | 1 = fault on misaligned loads, 0 = split them |
| req_valid | input | 1 | Load request valid |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | ADDR_W | Byte address of the load |
| req_size | input | 2 | Size code: 0 byte, 1 half, 2/3 word |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_fault | output | 1 | Response is an alignment fault |
| rsp_data | output | 32 | Zero-extended, right-aligned load result |
| bus_req_valid | output | 1 | Bus read request valid |
| bus_req_ready | input | 1 | Bus accepts the read request |
| bus_word_addr | output | ADDR_W-log2(DATA_W/8) | Word address of the bus read |
| bus_rsp_valid | input | 1 | Bus read data valid |
| bus_rsp_data | input | DATA_W | Bus read data word |

## Verification
Two functions of this block can meet in the same cycle. One is the decision between splitting and faulting, which is taken from `trap_mode` at acceptance. The other is an in-flight split whose second bus read is still pending. The bench flips `trap_mode` in the cycle directly after a straddling load is accepted, while the first bus read is outstanding. It then judges the load by its returned bytes and its two observed bus reads, which must show that the flip was ignored. The same flip is also made so that it coincides with a fault response, and the bench requires that fault response to stay a single, data-free pulse with no bus read.

// File: rtl/ldsplit_pkg.sv
package ldsplit_pkg;

   localparam int RES_W = 32;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD_LO,
      ST_WT_LO,
      ST_RD_HI,
      ST_WT_HI,
      ST_RESP
   } ld_state_e;

   // size code to byte count; codes 2 and 3 both select a full 4-byte load
   function automatic logic [2:0] size_bytes(input logic [1:0] code);
      case (code)
         2'd0:    return 3'd1;
         2'd1:    return 3'd2;
         default: return 3'd4;
      endcase
   endfunction

endpackage

// File: rtl/ldsplit_decode.sv
module ldsplit_decode #(
   parameter int LANES = 4,
   parameter int OFS_W = 2
) (
   input  logic [OFS_W-1:0] ofs,
   input  logic [1:0]       size,
   output logic             misaligned,
   output logic             straddle
);
   import ldsplit_pkg::*;

   logic [2:0]       nbytes;
   logic [OFS_W-1:0] low_mask;
   logic [OFS_W:0]   end_pos;

   always_comb begin
      nbytes     = size_bytes(size);
      low_mask   = OFS_W'(nbytes - 3'd1);
      misaligned = |(ofs & low_mask);
      end_pos    = {1'b0, ofs} + (OFS_W+1)'(nbytes);
      straddle   = end_pos > (OFS_W+1)'(LANES);
   end

endmodule

// File: rtl/ldsplit_ctrl.sv
module ldsplit_ctrl #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int OFS_W  = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    trap_mode,
   input  logic                    req_valid,
   input  logic [ADDR_W-1:0]       req_addr,
   input  logic [1:0]              req_size,
   input  logic                    misaligned,
   input  logic                    straddle,
   input  logic                    bus_req_ready,
   input  logic                    bus_rsp_valid,
   input  logic [DATA_W-1:0]       bus_rsp_data,
   output logic                    req_ready,
   output logic                    bus_req_valid,
   output logic [ADDR_W-OFS_W-1:0] bus_word_addr,
   output logic                    rsp_valid,
   output logic                    rsp_fault,
   output logic [DATA_W-1:0]       lo_q,
   output logic [DATA_W-1:0]       hi_q,
   output logic [OFS_W-1:0]        ofs_q,
   output logic [1:0]              size_q
);
   import ldsplit_pkg::*;

   localparam int WA_W = ADDR_W - OFS_W;

   ld_state_e       state;
   logic [WA_W-1:0] wa_q;
   logic            split_q;
   logic            fault_q;
   logic            accept;

   assign accept = req_valid && (state == ST_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         wa_q    <= '0;
         ofs_q   <= '0;
         size_q  <= '0;
         split_q <= 1'b0;
         fault_q <= 1'b0;
         lo_q    <= '0;
         hi_q    <= '0;
      end else begin
         unique case (state)
            ST_IDLE: if (accept) begin
               wa_q    <= req_addr[ADDR_W-1:OFS_W];
               ofs_q   <= req_addr[OFS_W-1:0];
               size_q  <= req_size;
               split_q <= straddle;
               fault_q <= trap_mode && misaligned;
               hi_q    <= '0;
               state   <= (trap_mode && misaligned) ? ST_RESP : ST_RD_LO;
            end
            ST_RD_LO: if (bus_req_ready) state <= ST_WT_LO;
            ST_WT_LO: if (bus_rsp_valid) begin
               lo_q  <= bus_rsp_data;
               state <= split_q ? ST_RD_HI : ST_RESP;
            end
            ST_RD_HI: if (bus_req_ready) state <= ST_WT_HI;
            ST_WT_HI: if (bus_rsp_valid) begin
               hi_q  <= bus_rsp_data;
               state <= ST_RESP;
            end
            ST_RESP: state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      req_ready     = (state == ST_IDLE);
      bus_req_valid = (state == ST_RD_LO) || (state == ST_RD_HI);
      bus_word_addr = (state == ST_RD_HI) ? wa_q + WA_W'(1) : wa_q;
      rsp_valid     = (state == ST_RESP);
      rsp_fault     = (state == ST_RESP) && fault_q;
   end

endmodule

// File: rtl/ldsplit_merge.sv
module ldsplit_merge #(
   parameter int DATA_W = 32,
   parameter int OFS_W  = 2
) (
   input  logic [DATA_W-1:0]            lo,
   input  logic [DATA_W-1:0]            hi,
   input  logic [OFS_W-1:0]             ofs,
   input  logic [1:0]                   size,
   input  logic                         fault,
   output logic [ldsplit_pkg::RES_W-1:0] data
);
   import ldsplit_pkg::*;

   localparam int RES_BYTES = RES_W / 8;

   logic [2*DATA_W-1:0] pair_shifted;
   logic [2:0]          nbytes;

   always_comb begin
      pair_shifted = {hi, lo} >> {ofs, 3'b000};
      nbytes       = size_bytes(size);
   end

   for (genvar i = 0; i < RES_BYTES; i++) begin : g_lane
      assign data[i*8 +: 8] = (!fault && (nbytes > 3'(i))) ? pair_shifted[i*8 +: 8] : 8'h00;
   end

endmodule

// File: rtl/ld_split_unit.sv
module ld_split_unit #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic                                  trap_mode,
   input  logic                                  req_valid,
   output logic                                  req_ready,
   input  logic [ADDR_W-1:0]                     req_addr,
   input  logic [1:0]                            req_size,
   output logic                                  rsp_valid,
   output logic                                  rsp_fault,
   output logic [31:0]                           rsp_data,
   output logic                                  bus_req_valid,
   input  logic                                  bus_req_ready,
   output logic [ADDR_W-$clog2(DATA_W/8)-1:0]    bus_word_addr,
   input  logic                                  bus_rsp_valid,
   input  logic [DATA_W-1:0]                     bus_rsp_data
);
   localparam int LANES = DATA_W / 8;
   localparam int OFS_W = $clog2(LANES);

   if ((DATA_W % 8) != 0 || LANES < 4 || (1 << OFS_W) != LANES) begin : g_bad_width
      $error("ld_split_unit: DATA_W must be a power-of-two byte count of at least 4 bytes");
   end
   if (ADDR_W <= OFS_W) begin : g_bad_addr
      $error("ld_split_unit: ADDR_W must exceed the byte offset width");
   end

   logic              misaligned;
   logic              straddle;
   logic [DATA_W-1:0] lo_q;
   logic [DATA_W-1:0] hi_q;
   logic [OFS_W-1:0]  ofs_q;
   logic [1:0]        size_q;

   ldsplit_decode #(.LANES(LANES), .OFS_W(OFS_W)) u_decode (
      .ofs        (req_addr[OFS_W-1:0]),
      .size       (req_size),
      .misaligned (misaligned),
      .straddle   (straddle)
   );

   ldsplit_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFS_W(OFS_W)) u_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .trap_mode     (trap_mode),
      .req_valid     (req_valid),
      .req_addr      (req_addr),
      .req_size      (req_size),
      .misaligned    (misaligned),
      .straddle      (straddle),
      .bus_req_ready (bus_req_ready),
      .bus_rsp_valid (bus_rsp_valid),
      .bus_rsp_data  (bus_rsp_data),
      .req_ready     (req_ready),
      .bus_req_valid (bus_req_valid),
      .bus_word_addr (bus_word_addr),
      .rsp_valid     (rsp_valid),
      .rsp_fault     (rsp_fault),
      .lo_q          (lo_q),
      .hi_q          (hi_q),
      .ofs_q         (ofs_q),
      .size_q        (size_q)
   );

   ldsplit_merge #(.DATA_W(DATA_W), .OFS_W(OFS_W)) u_merge (
      .lo    (lo_q),
      .hi    (hi_q),
      .ofs   (ofs_q),
      .size  (size_q),
      .fault (rsp_fault),
      .data  (rsp_data)
   );

endmodule

// File: rtl/ldsplit_checker.sv
module ldsplit_checker #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32
) (
   input logic                               clk,
   input logic                               rst_n,
   input logic                               req_valid,
   input logic                               req_ready,
   input logic                               rsp_valid,
   input logic                               rsp_fault,
   input logic [31:0]                        rsp_data,
   input logic                               bus_req_valid,
   input logic                               bus_req_ready,
   input logic [ADDR_W-$clog2(DATA_W/8)-1:0] bus_word_addr
);
   localparam int WA_W = ADDR_W - $clog2(DATA_W/8);

   logic [2:0]      rd_cnt;
   logic [WA_W-1:0] first_wa;

   // bus reads seen since the last accepted request
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_cnt   <= '0;
         first_wa <= '0;
      end else if (req_valid && req_ready) begin
         rd_cnt <= '0;
      end else if (bus_req_valid && bus_req_ready) begin
         if (rd_cnt != 3'd7) rd_cnt <= rd_cnt + 3'd1;
         if (rd_cnt == 3'd0) first_wa <= bus_word_addr;
      end
   end

   assert_hold_bus_req_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req_valid && !bus_req_ready) |=> (bus_req_valid && $stable(bus_word_addr)));

   assert_busy_after_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   assert_single_pulse_rsp_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> (!rsp_valid && req_ready));

   assert_fault_no_bus_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_fault) |-> (rsp_data == 32'h0 && rd_cnt == 3'd0));

   assert_max_two_reads_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rd_cnt <= 3'd2);

   assert_next_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req_valid && rd_cnt == 3'd1) |-> (bus_word_addr == first_wa + WA_W'(1)));

endmodule

bind ld_split_unit ldsplit_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/ld_split_unit_test.sv
`timescale 1ns/1ps
module ld_split_unit_test;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        trap_mode;
   logic        req_valid;
   logic        req_ready;
   logic [31:0] req_addr;
   logic [1:0]  req_size;
   logic        rsp_valid;
   logic        rsp_fault;
   logic [31:0] rsp_data;
   logic        bus_req_valid;
   logic        bus_req_ready;
   logic [29:0] bus_word_addr;
   logic        bus_rsp_valid;
   logic [31:0] bus_rsp_data;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   // bus model state
   int          bus_lat    = 0;
   int          stall_req  = 0;
   int          reads      = 0;
   logic [29:0] rd_log [8];

   always #2.5 clk = ~clk;

   ld_split_unit #(.ADDR_W(32), .DATA_W(32)) uut (.*);

   function automatic logic [7:0] mem_byte(input logic [31:0] a);
      return 8'(a * 32'd37 + 32'h5A);
   endfunction

   function automatic logic [31:0] mem_word(input logic [29:0] wa);
      logic [31:0] base = {wa, 2'b00};
      return {mem_byte(base + 3), mem_byte(base + 2), mem_byte(base + 1), mem_byte(base)};
   endfunction

   function automatic logic [31:0] exp_load(input logic [31:0] a, input logic [1:0] sz);
      int n = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
      logic [31:0] v = '0;
      for (int k = 0; k < n; k++) v[k*8 +: 8] = mem_byte(a + 32'(k));
      return v;
   endfunction

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, expv);
      end
   endtask

   // bus responder: word-wide reads, optional accept stall and read latency
   initial begin
      int          pend_cnt = 0;
      bit          pend = 1'b0;
      logic [29:0] pend_wa = '0;
      bit          stalling = 1'b0;
      logic [29:0] stall_wa = '0;
      bus_req_ready = 1'b1;
      bus_rsp_valid = 1'b0;
      bus_rsp_data  = '0;
      forever begin
         @(negedge clk);
         bus_rsp_valid = 1'b0;
         if (pend) begin
            if (pend_cnt == 0) begin
               bus_rsp_valid = 1'b1;
               bus_rsp_data  = mem_word(pend_wa);
               pend = 1'b0;
            end else pend_cnt--;
         end else if (bus_req_valid) begin
            if (stalling) check(bus_word_addr == stall_wa, "R12 address held in stall", 32'(bus_word_addr), 32'(stall_wa));
            if (stall_req > 0) begin
               bus_req_ready = 1'b0;
               stalling = 1'b1;
               stall_wa = bus_word_addr;
               stall_req--;
            end else begin
               bus_req_ready = 1'b1;
               stalling = 1'b0;
               rd_log[reads & 7] = bus_word_addr;
               reads++;
               pend = 1'b1;
               pend_wa = bus_word_addr;
               pend_cnt = bus_lat;
            end
         end else begin
            bus_req_ready = 1'b1;
         end
      end
   end

   task automatic do_load(input logic [31:0] a, input logic [1:0] sz, input int exp_reads,
                          input bit exp_fault, input bit flip, input string req);
      int          start;
      logic [31:0] expv;
      @(negedge clk);
      start = reads;
      check(req_ready, {req, " ready when idle"}, 32'(req_ready), 32'd1);
      req_addr  = a;
      req_size  = sz;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      if (flip) trap_mode = ~trap_mode;
      check(!req_ready || rsp_valid, "R10 busy after accept", 32'(req_ready), 32'd0);
      for (int c = 0; c < 60 && !rsp_valid; c++) @(negedge clk);
      expv = exp_fault ? 32'h0 : exp_load(a, sz);
      check(rsp_valid, {req, " response seen"}, 32'(rsp_valid), 32'd1);
      check(rsp_data == expv, {req, " data"}, rsp_data, expv);
      check(rsp_fault == exp_fault, {req, " fault flag"}, 32'(rsp_fault), 32'(exp_fault));
      check(reads - start == exp_reads, {req, " bus read count"}, 32'(reads - start), 32'(exp_reads));
      if (exp_reads >= 1)
         check(rd_log[start & 7] == a[31:2], "R2 first word address", 32'(rd_log[start & 7]), 32'(a[31:2]));
      if (exp_reads == 2)
         check(rd_log[(start + 1) & 7] == a[31:2] + 30'd1, "R6 second word address",
               32'(rd_log[(start + 1) & 7]), 32'(a[31:2] + 30'd1));
      @(negedge clk);
      check(!rsp_valid && req_ready, "R10 single pulse then ready", {30'd0, rsp_valid, req_ready}, 32'd1);
   endtask

   task automatic t_reset;
      @(negedge clk);
      check(req_ready && !rsp_valid && !bus_req_valid, "R1 reset state",
            {29'd0, req_ready, rsp_valid, bus_req_valid}, 32'd4);
   endtask

   task automatic t_bytes;
      for (int o = 0; o < 4; o++) do_load(32'h0000_1040 + 32'(o), 2'd0, 1, 1'b0, 1'b0, "R3 byte load");
   endtask

   task automatic t_aligned;
      do_load(32'h0000_2000, 2'd1, 1, 1'b0, 1'b0, "R4 half at 0");
      do_load(32'h0000_2002, 2'd1, 1, 1'b0, 1'b0, "R4 half at 2");
      do_load(32'h0000_2004, 2'd2, 1, 1'b0, 1'b0, "R4 word aligned");
   endtask

   task automatic t_inword;
      do_load(32'h0000_3001, 2'd1, 1, 1'b0, 1'b0, "R5 half at offset 1");
   endtask

   task automatic t_straddle;
      do_load(32'h0000_4003, 2'd1, 2, 1'b0, 1'b0, "R6 half at offset 3");
      do_load(32'h0000_4011, 2'd2, 2, 1'b0, 1'b0, "R6 word at offset 1");
      do_load(32'h0000_4022, 2'd2, 2, 1'b0, 1'b0, "R6 word at offset 2");
      do_load(32'h0000_4033, 2'd2, 2, 1'b0, 1'b0, "R6 word at offset 3");
      do_load(32'hFFFF_FFFE, 2'd2, 2, 1'b0, 1'b0, "R6 word wrapping to address 0");
   endtask

   task automatic t_endian;
      do_load(32'h0000_5006, 2'd3, 2, 1'b0, 1'b0, "R7 size code 3 as word");
      do_load(32'h0000_5010, 2'd2, 1, 1'b0, 1'b0, "R7 little-endian order");
   endtask

   task automatic t_fault;
      trap_mode = 1'b1;
      do_load(32'h0000_6001, 2'd1, 0, 1'b1, 1'b0, "R8 half at 1 faults");
      do_load(32'h0000_6003, 2'd1, 0, 1'b1, 1'b0, "R8 half at 3 faults");
      do_load(32'h0000_6006, 2'd2, 0, 1'b1, 1'b0, "R8 word at 2 faults");
      trap_mode = 1'b0;
   endtask

   task automatic t_trap_aligned;
      trap_mode = 1'b1;
      do_load(32'h0000_7008, 2'd2, 1, 1'b0, 1'b0, "R9 aligned word in trap mode");
      do_load(32'h0000_7005, 2'd0, 1, 1'b0, 1'b0, "R9 byte in trap mode");
      trap_mode = 1'b0;
   endtask

   task automatic t_mode_flip;
      bus_lat = 3;
      trap_mode = 1'b0;
      do_load(32'h0000_8101, 2'd2, 2, 1'b0, 1'b1, "R11 flip to trap mid-split");
      trap_mode = 1'b1;
      do_load(32'h0000_8203, 2'd1, 0, 1'b1, 1'b1, "R11 flip during fault response");
      trap_mode = 1'b0;
      bus_lat = 0;
   endtask

   task automatic t_stall;
      stall_req = 3;
      bus_lat   = 2;
      do_load(32'h0000_9002, 2'd2, 2, 1'b0, 1'b0, "R12 stalled bus split");
      bus_lat   = 0;
   endtask

   initial begin
      rst_n     = 1'b0;
      trap_mode = 1'b0;
      req_valid = 1'b0;
      req_addr  = '0;
      req_size  = '0;
      repeat (3) @(posedge clk);
      t_reset();
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_bytes();
      t_aligned();
      t_inword();
      t_straddle();
      t_endian();
      t_fault();
      t_trap_aligned();
      t_mode_flip();
      t_stall();
      repeat (2) @(negedge clk);
      if (!finished) begin
         finished = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
         $finish;
      end
   end

endmodule